// File: doc/BRIEF.md
# Serial EEPROM Access Controller

This block sits between a host register bus and an external byte-addressed EEPROM. Software can fetch or store one EEPROM byte at a time. It sets an address register and, for a store, a data register. It then raises a request bit in the control register and polls until the hardware drops that bit again. When a fetch ends, the fetched byte sits in the data register.

The block can also run an autonomous burst. It walks the EEPROM from an internal next-address pointer and reads three-byte records. Each record holds a 16-bit address field, low byte first, then one data byte. For every record the block issues a memory write. The memory address is formed from a host-programmed 9-bit base and the low 15 bits of the record's address field. The burst stops at a record whose address field is 0xFFFF.

The EEPROM side and the memory side are valid/ready streams. A source raises valid and holds it, with all of its fields unchanged, until the cycle in which ready is also high. A transfer takes place on a clock edge where valid and ready are both high. The EEPROM answers each accepted request with a one-cycle response pulse. The controller waits for this pulse and never applies back-pressure to it. The register bus is a plain write strobe with a combinational read mux.

Top module: `eeprom_access_ctrl`

## Requirements
- R1: After reset, every register reads 0, no EEPROM request or memory write is offered, and the busy bit (control bit 2) is 0.
- R2: Writing the control register at offset 0 with bit 0 set, while idle, issues one EEPROM write of the low byte of the data register (offset 2) at the address held in the address register (offset 1). Bit 0 reads 1 until the acknowledge arrives and clears by itself after it.
- R3: Writing control bit 1 while idle issues one EEPROM read at the address register. The returned byte is loaded into the data register on the same edge that clears bit 1, so the data is valid once bit 1 reads 0.
- R4: If bits 0 and 1 are both set in one control write, only the read is performed and the EEPROM contents are left unchanged.
- R5: Busy (control bit 2) reads 1 for the whole of any single or burst operation. Single requests and burst starts written while busy are ignored: no extra EEPROM request is issued, and no request bit is set.
- R6: Writing bit 0 of the burst register (offset 3) while idle starts a burst. That bit reads 1 until the burst ends and then clears by itself. Each record is read as address low byte, address high byte, then data byte, and produces exactly one memory write. A record whose address field is 0xFFFF ends the burst without a memory write.
- R7: The next-address pointer is 0 after reset. A single access at address A sets it to A+1, and each byte read by a burst advances it by one. The pointer wraps to 0 past EE_BYTES-1, and a burst begins at the pointer.
- R8: The memory write address is the base register (offset 4, 9 bits) in bits 23:15, concatenated with bits 14:0 of the record's address field. Bit 15 of the field is ignored.
- R9: If a read response and a host write to the data register fall in the same cycle, the data register takes the EEPROM byte.
- R10: An offered EEPROM request or memory write keeps valid high and its fields stable until ready is seen. Memory writes issue in record order under any ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | REG_DW (32) | Register write data |
| reg_rdata | output | REG_DW (32) | Register read data for reg_addr |
| ee_req_valid | output | 1 | EEPROM request offered |
| ee_req_ready | input | 1 | EEPROM accepts request |
| ee_req_we | output | 1 | 1 = byte write, 0 = byte read |
| ee_req_addr | output | AW (11) | EEPROM byte address |
| ee_req_wdata | output | 8 | Byte to store |
| ee_rsp_valid | input | 1 | One-cycle acknowledge of an accepted request |
| ee_rsp_data | input | 8 | Fetched byte (read requests) |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts write |
| mem_addr | output | BASE_W+15 (24) | Memory byte address |
| mem_data | output | 8 | Memory write data |

## Verification
Two events can fall in the same clock cycle. The first pair is an EEPROM read response and a host write to the data register. The bench holds the responder back, then drives the acknowledge pulse and the register write on the same edge. It expects the fetched byte to win. The second case is a new request or burst start written while an operation is still in flight. It is provoked by stalling the response. The bench judges it at the ports: it reads the control and burst registers back, counts the requests seen by the responder, and confirms that the EEPROM byte a stray write would have hit is unchanged.

// File: rtl/eeac_pkg.sv
package eeac_pkg;
  // register word offsets
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_ADDR  = 3'd1;
  localparam logic [2:0] RA_DATA  = 3'd2;
  localparam logic [2:0] RA_BURST = 3'd3;
  localparam logic [2:0] RA_BASE  = 3'd4;

  // control register bit positions
  localparam int CB_WR   = 0;
  localparam int CB_RD   = 1;
  localparam int CB_BUSY = 2;

  localparam int FIELD_W = 15;
  localparam logic [15:0] END_MARK = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S_REQ,
    ST_S_RSP,
    ST_B_REQ,
    ST_B_RSP,
    ST_B_MEM
  } eeac_state_e;

  typedef enum logic [1:0] {
    FLD_LO,
    FLD_HI,
    FLD_DAT
  } eeac_field_e;
endpackage

// File: rtl/eeac_regs.sv
module eeac_regs
  import eeac_pkg::*;
#(
  parameter int AW     = 11,
  parameter int BASE_W = 9,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              rd_done_i,
  input  logic [7:0]        rd_data_i,
  input  logic              burst_done_i,
  output logic              start_single_o,
  output logic              start_rd_o,
  output logic              start_burst_o,
  output logic [AW-1:0]     addr_o,
  output logic [7:0]        data_o,
  output logic [BASE_W-1:0] base_o
);
  logic wr_pend_q, rd_pend_q, burst_run_q;
  logic [AW-1:0]     addr_q;
  logic [7:0]        data_q;
  logic [BASE_W-1:0] base_q;
  logic unused_wdata;

  assign unused_wdata   = ^reg_wdata;
  assign start_single_o = reg_wr && (reg_addr == RA_CTRL) && !busy_i &&
                          (reg_wdata[CB_WR] || reg_wdata[CB_RD]);
  assign start_rd_o     = reg_wdata[CB_RD];
  assign start_burst_o  = reg_wr && (reg_addr == RA_BURST) && !busy_i && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend_q   <= 1'b0;
      rd_pend_q   <= 1'b0;
      burst_run_q <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      base_q      <= '0;
    end else begin
      if (start_single_o) begin
        rd_pend_q <= start_rd_o;
        wr_pend_q <= !start_rd_o;
      end else if (done_i) begin
        rd_pend_q <= 1'b0;
        wr_pend_q <= 1'b0;
      end
      if (start_burst_o)     burst_run_q <= 1'b1;
      else if (burst_done_i) burst_run_q <= 1'b0;
      if (reg_wr && reg_addr == RA_ADDR) addr_q <= reg_wdata[AW-1:0];
      if (reg_wr && reg_addr == RA_BASE) base_q <= reg_wdata[BASE_W-1:0];
      // engine result has priority over a host write in the same cycle
      if (rd_done_i)                          data_q <= rd_data_i;
      else if (reg_wr && reg_addr == RA_DATA) data_q <= reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_WR]   = wr_pend_q;
        reg_rdata[CB_RD]   = rd_pend_q;
        reg_rdata[CB_BUSY] = busy_i;
      end
      RA_ADDR:  reg_rdata[AW-1:0]     = addr_q;
      RA_DATA:  reg_rdata[7:0]        = data_q;
      RA_BURST: reg_rdata[0]          = burst_run_q;
      RA_BASE:  reg_rdata[BASE_W-1:0] = base_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign base_o = base_q;

  AST_PEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend_q || wr_pend_q) |-> busy_i); // R5
  AST_BURST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    burst_run_q |-> busy_i); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !(rd_pend_q || wr_pend_q)); // R3
endmodule

// File: rtl/eeac_ptr.sv
module eeac_ptr #(
  parameter int EE_BYTES = 2048,
  parameter int AW       = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(EE_BYTES - 1);

  logic [AW-1:0] ptr_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= step(load_val_i);
    else if (inc_i)  ptr_q <= step(ptr_q);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/eeac_engine.sv
module eeac_engine
  import eeac_pkg::*;
#(
  parameter int AW     = 11,
  parameter int BASE_W = 9,
  localparam int MEM_AW = BASE_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_single_i,
  input  logic              start_rd_i,
  input  logic              start_burst_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        data_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [AW-1:0]     ptr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_done_o,
  output logic [7:0]        rd_data_o,
  output logic              burst_done_o,
  output logic              ptr_load_o,
  output logic [AW-1:0]     ptr_load_val_o,
  output logic              ptr_inc_o,
  output logic              ee_req_valid,
  input  logic              ee_req_ready,
  output logic              ee_req_we,
  output logic [AW-1:0]     ee_req_addr,
  output logic [7:0]        ee_req_wdata,
  input  logic              ee_rsp_valid,
  input  logic [7:0]        ee_rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_data
);
  eeac_state_e       state_q;
  eeac_field_e       field_q;
  logic              op_we_q;
  logic [AW-1:0]     op_addr_q;
  logic [7:0]        op_wdata_q, lo_q, hi_q, mem_data_q;
  logic [MEM_AW-1:0] mem_addr_q;
  logic in_burst, s_fin, b_got;
  logic unused_hi;

  assign unused_hi = hi_q[7];
  assign in_burst  = (state_q == ST_B_REQ) || (state_q == ST_B_RSP) || (state_q == ST_B_MEM);
  assign s_fin     = (state_q == ST_S_RSP) && ee_rsp_valid;
  assign b_got     = (state_q == ST_B_RSP) && ee_rsp_valid;

  assign busy_o         = state_q != ST_IDLE;
  assign done_o         = s_fin;
  assign rd_done_o      = s_fin && !op_we_q;
  assign rd_data_o      = ee_rsp_data;
  assign ptr_load_o     = s_fin;
  assign ptr_load_val_o = op_addr_q;
  assign ptr_inc_o      = b_got;
  assign burst_done_o   = b_got && (field_q == FLD_HI) && ({ee_rsp_data, lo_q} == END_MARK);

  assign ee_req_valid = (state_q == ST_S_REQ) || (state_q == ST_B_REQ);
  assign ee_req_we    = op_we_q;
  assign ee_req_addr  = in_burst ? ptr_i : op_addr_q;
  assign ee_req_wdata = op_wdata_q;
  assign mem_valid    = state_q == ST_B_MEM;
  assign mem_addr     = mem_addr_q;
  assign mem_data     = mem_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      field_q    <= FLD_LO;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      mem_addr_q <= '0;
      mem_data_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_single_i) begin
            op_we_q    <= !start_rd_i;
            op_addr_q  <= addr_i;
            op_wdata_q <= data_i;
            state_q    <= ST_S_REQ;
          end else if (start_burst_i) begin
            op_we_q <= 1'b0;
            field_q <= FLD_LO;
            state_q <= ST_B_REQ;
          end
        end
        ST_S_REQ: if (ee_req_ready) state_q <= ST_S_RSP;
        ST_S_RSP: if (ee_rsp_valid) state_q <= ST_IDLE;
        ST_B_REQ: if (ee_req_ready) state_q <= ST_B_RSP;
        ST_B_RSP: begin
          if (ee_rsp_valid) begin
            unique case (field_q)
              FLD_LO: begin
                lo_q    <= ee_rsp_data;
                field_q <= FLD_HI;
                state_q <= ST_B_REQ;
              end
              FLD_HI: begin
                hi_q    <= ee_rsp_data;
                field_q <= FLD_DAT;
                state_q <= burst_done_o ? ST_IDLE : ST_B_REQ;
              end
              default: begin
                mem_addr_q <= {base_i, hi_q[6:0], lo_q};
                mem_data_q <= ee_rsp_data;
                field_q    <= FLD_LO;
                state_q    <= ST_B_MEM;
              end
            endcase
          end
        end
        ST_B_MEM: if (mem_ready) state_q <= ST_B_REQ;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req_valid && !ee_req_ready) |=>
      (ee_req_valid && $stable(ee_req_addr) && $stable(ee_req_we) && $stable(ee_req_wdata))); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R10
endmodule

// File: rtl/eeprom_access_ctrl.sv
module eeprom_access_ctrl
  import eeac_pkg::*;
#(
  parameter int EE_BYTES = 2048,
  parameter int BASE_W   = 9,
  parameter int REG_DW   = 32,
  localparam int AW      = $clog2(EE_BYTES),
  localparam int MEM_AW  = BASE_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              ee_req_valid,
  input  logic              ee_req_ready,
  output logic              ee_req_we,
  output logic [AW-1:0]     ee_req_addr,
  output logic [7:0]        ee_req_wdata,
  input  logic              ee_rsp_valid,
  input  logic [7:0]        ee_rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_data
);
  logic busy, done, rd_done, burst_done, ptr_load, ptr_inc;
  logic start_single, start_rd, start_burst;
  logic [7:0]        rd_data, data_val;
  logic [AW-1:0]     addr_val, ptr, ptr_load_val;
  logic [BASE_W-1:0] base_val;

  eeac_regs #(.AW(AW), .BASE_W(BASE_W), .REG_DW(REG_DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_i(busy), .done_i(done), .rd_done_i(rd_done), .rd_data_i(rd_data),
    .burst_done_i(burst_done),
    .start_single_o(start_single), .start_rd_o(start_rd), .start_burst_o(start_burst),
    .addr_o(addr_val), .data_o(data_val), .base_o(base_val)
  );

  eeac_ptr #(.EE_BYTES(EE_BYTES), .AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load_i(ptr_load), .load_val_i(ptr_load_val), .inc_i(ptr_inc), .ptr_o(ptr)
  );

  eeac_engine #(.AW(AW), .BASE_W(BASE_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_single_i(start_single), .start_rd_i(start_rd), .start_burst_i(start_burst),
    .addr_i(addr_val), .data_i(data_val), .base_i(base_val), .ptr_i(ptr),
    .busy_o(busy), .done_o(done), .rd_done_o(rd_done), .rd_data_o(rd_data),
    .burst_done_o(burst_done),
    .ptr_load_o(ptr_load), .ptr_load_val_o(ptr_load_val), .ptr_inc_o(ptr_inc),
    .ee_req_valid(ee_req_valid), .ee_req_ready(ee_req_ready), .ee_req_we(ee_req_we),
    .ee_req_addr(ee_req_addr), .ee_req_wdata(ee_req_wdata),
    .ee_rsp_valid(ee_rsp_valid), .ee_rsp_data(ee_rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );
endmodule

// File: tb/eeprom_access_ctrl_tb.sv
module eeprom_access_ctrl_tb_top;
  localparam int EE_BYTES = 2048;
  localparam int AW       = 11;
  localparam int MEM_AW   = 24;
  localparam logic [2:0] A_CTRL = 3'd0, A_ADDR = 3'd1, A_DATA = 3'd2, A_BURST = 3'd3, A_BASE = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ee_req_valid, ee_req_we;
  logic ee_req_ready = 1'b0;
  logic [AW-1:0] ee_req_addr;
  logic [7:0] ee_req_wdata;
  logic ee_rsp_valid = 1'b0;
  logic [7:0] ee_rsp_data = '0;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0] mem_data;

  always #10 clk = ~clk;

  eeprom_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ee_req_valid(ee_req_valid), .ee_req_ready(ee_req_ready),
    .ee_req_we(ee_req_we), .ee_req_addr(ee_req_addr), .ee_req_wdata(ee_req_wdata),
    .ee_rsp_valid(ee_rsp_valid), .ee_rsp_data(ee_rsp_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] eemem [EE_BYTES];
  bit manual = 0, mem_bp = 0;
  int pending = 0, cnt = 0, lat = 1, req_count = 0;
  logic [7:0] rsp_byte = '0;
  logic [MEM_AW-1:0] log_addr [64];
  logic [7:0] log_data [64];
  int log_n = 0;
  logic [MEM_AW-1:0] exp_addr [64];
  logic [7:0] exp_data [64];
  int exp_n = 0;
  int exp_ptr = 0;

  // behavioural EEPROM responder and memory sink
  always @(negedge clk) begin
    if (!manual) begin
      ee_rsp_valid = 1'b0;
      if (pending != 0) begin
        if (cnt == 0) begin
          ee_rsp_valid = 1'b1;
          ee_rsp_data  = rsp_byte;
          pending      = 0;
        end else cnt--;
      end
    end
    ee_req_ready = (pending == 0) && !ee_rsp_valid && ($urandom_range(0, 3) != 0);
    if (ee_req_valid && ee_req_ready) begin
      req_count++;
      pending = 1;
      cnt = lat;
      if (ee_req_we) begin
        eemem[ee_req_addr] = ee_req_wdata;
        rsp_byte = 8'h00;
      end else rsp_byte = eemem[ee_req_addr];
    end
    mem_ready = mem_bp ? 1'($urandom_range(0, 1)) : 1'b1;
    if (mem_valid && mem_ready && log_n < 64) begin
      log_addr[log_n] = mem_addr;
      log_data[log_n] = mem_data;
      log_n++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'h4;
    while (v[2]) reg_read(A_CTRL, v);
  endtask

  function automatic int burst_model(input int start, input logic [8:0] base);
    int p;
    logic [7:0] lo, hi, d;
    p = start;
    exp_n = 0;
    for (int k = 0; k < 40; k++) begin
      lo = eemem[p]; p = (p + 1) % EE_BYTES;
      hi = eemem[p]; p = (p + 1) % EE_BYTES;
      if ({hi, lo} == 16'hFFFF) return p;
      d = eemem[p]; p = (p + 1) % EE_BYTES;
      exp_addr[exp_n] = {base, hi[6:0], lo};
      exp_data[exp_n] = d;
      exp_n++;
    end
    return p;
  endfunction

  task automatic put_rec(inout int p, input logic [15:0] a, input logic [7:0] d);
    eemem[p] = a[7:0];  p = (p + 1) % EE_BYTES;
    eemem[p] = a[15:8]; p = (p + 1) % EE_BYTES;
    eemem[p] = d;       p = (p + 1) % EE_BYTES;
  endtask

  task automatic run_burst(input logic [8:0] base, input string tag);
    logic [31:0] v;
    int e;
    reg_write(A_BASE, {23'd0, base});
    log_n = 0;
    e = burst_model(exp_ptr, base);
    reg_write(A_BURST, 32'd1);
    reg_read(A_BURST, v);
    check("R6", {tag, " burst bit set while running"}, v[0], 1'b1);
    wait_idle();
    reg_read(A_BURST, v);
    check("R6", {tag, " burst bit self-clears"}, v, 32'd0);
    check("R6", {tag, " record count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check("R8", {tag, " mem address"}, log_addr[i], exp_addr[i]);
      check("R10", {tag, " mem data in order"}, log_data[i], exp_data[i]);
    end
    exp_ptr = e;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [31:0] v;
    int p, a, rc;
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < EE_BYTES; i++) eemem[i] = 8'($urandom_range(0, 254));
    // records at address 0
    p = 0;
    put_rec(p, 16'h1234, 8'hAA);
    put_rec(p, 16'h8003, 8'h55);   // bit 15 must be dropped
    put_rec(p, 16'h7FFF, 8'h0F);
    eemem[p] = 8'hFF; eemem[p + 1] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(A_CTRL, v);  check("R1", "ctrl after reset", v, 0);
    reg_read(A_ADDR, v);  check("R1", "addr after reset", v, 0);
    reg_read(A_DATA, v);  check("R1", "data after reset", v, 0);
    reg_read(A_BURST, v); check("R1", "burst after reset", v, 0);
    reg_read(A_BASE, v);  check("R1", "base after reset", v, 0);
    check("R1", "no request after reset", {ee_req_valid, mem_valid}, 0);

    // R7 burst before any access starts at 0
    run_burst(9'h1A5, "R7 first burst");

    // R2 single write
    reg_write(A_ADDR, 100);
    reg_write(A_DATA, 32'hFF5E);
    reg_write(A_CTRL, 32'h1);
    reg_read(A_CTRL, v);
    check("R2", "write bit pending", v, 32'h5);
    wait_idle();
    reg_read(A_CTRL, v);
    check("R2", "write bit self-clears", v, 0);
    check("R2", "eeprom byte stored", eemem[100], 8'h5E);
    exp_ptr = 101;

    // R3 single read
    reg_write(A_DATA, 0);
    reg_write(A_CTRL, 32'h2);
    wait_idle();
    reg_read(A_CTRL, v); check("R3", "read bit self-clears", v, 0);
    reg_read(A_DATA, v); check("R3", "read data", v, 32'h5E);
    exp_ptr = 101;

    // R7 burst continues after last access, with back-pressure
    p = 101;
    put_rec(p, 16'($urandom_range(0, 16'hFFFE)), 8'($urandom));
    put_rec(p, 16'($urandom_range(0, 16'hFFFE)), 8'($urandom));
    eemem[p] = 8'hFF; eemem[p + 1] = 8'hFF;
    mem_bp = 1; lat = 2;
    run_burst(9'($urandom), "R7 continued burst");

    // random single accesses
    for (int k = 0; k < 24; k++) begin
      a = $urandom_range(200, 1999);
      lat = $urandom_range(0, 3);
      reg_write(A_ADDR, a);
      if ($urandom_range(0, 1) == 1) begin
        d = 8'($urandom);
        reg_write(A_DATA, {24'd0, d});
        reg_write(A_CTRL, 32'h1);
        wait_idle();
        check("R2", "random write", eemem[a], d);
      end else begin
        reg_write(A_CTRL, 32'h2);
        wait_idle();
        reg_read(A_DATA, v);
        check("R3", "random read", v, {24'd0, eemem[a]});
      end
      exp_ptr = a + 1;
    end

    // R7 wrap: access at the last byte, then burst begins at 0
    reg_write(A_ADDR, EE_BYTES - 1);
    reg_write(A_CTRL, 32'h2);
    wait_idle();
    exp_ptr = 0;
    run_burst(9'h0C3, "R7 wrap");

    // R4 both request bits: read only
    eemem[300] = 8'h77;
    reg_write(A_ADDR, 300);
    reg_write(A_DATA, 32'h11);
    reg_write(A_CTRL, 32'h3);
    wait_idle();
    reg_read(A_DATA, v);
    check("R4", "both bits reads", v, 32'h77);
    check("R4", "both bits leaves eeprom", eemem[300], 8'h77);

    // R5 requests while busy are ignored
    manual = 1;
    eemem[400] = 8'h21; eemem[401] = 8'h99;
    reg_write(A_ADDR, 400);
    reg_write(A_CTRL, 32'h2);
    while (pending == 0) @(negedge clk);
    rc = req_count;
    reg_write(A_ADDR, 401);
    reg_write(A_DATA, 32'hEE);
    reg_write(A_CTRL, 32'h1);
    reg_read(A_CTRL, v);
    check("R5", "ctrl while busy", v, 32'h6);
    reg_write(A_BURST, 32'h1);
    reg_read(A_BURST, v);
    check("R5", "burst start ignored", v, 0);
    @(negedge clk);
    ee_rsp_valid = 1'b1; ee_rsp_data = eemem[400]; pending = 0;
    @(negedge clk);
    ee_rsp_valid = 1'b0;
    repeat (20) @(negedge clk);
    check("R5", "no extra request", req_count, rc);
    check("R5", "stray write not stored", eemem[401], 8'h99);
    reg_read(A_DATA, v);
    check("R3", "read data after busy", v, 32'h21);
    reg_read(A_CTRL, v);
    check("R5", "idle after op", v, 0);

    // R9 response and host data write in the same cycle
    reg_write(A_ADDR, 500);
    reg_write(A_CTRL, 32'h2);
    while (pending == 0) @(negedge clk);
    @(negedge clk);
    ee_rsp_valid = 1'b1; ee_rsp_data = 8'hA5; pending = 0;
    reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 32'h3C;
    @(negedge clk);
    ee_rsp_valid = 1'b0; reg_wr = 1'b0;
    reg_read(A_DATA, v);
    check("R9", "engine wins data register", v, 32'hA5);
    reg_read(A_CTRL, v);
    check("R3", "collision clears read bit", v, 0);
    manual = 0;

    report();
  end
endmodule